// File: doc/BRIEF.md
# Serial-Load Shift Register Peripheral

This block is a small register-mapped peripheral on a single-beat, AXI-Lite-style register port. Software feeds a 4-bit word in one bit at a time. Each write to the control word sets a serial input bit and a shift-enable bit. While the enable is set, an internal register moves left by one place on every clock and takes the serial bit into its least significant position.

A second, read-only word shows a registered copy of the shift register, one cycle behind it. A master that wants to load a value writes the control word once per cycle, four times, highest bit first, with the enable set. It then writes the control word once more with the enable clear. After that it reads the data word to fetch the result.

Only exact, aligned offsets are decoded. Any other access, and any write to the read-only word, is answered with an error response and changes nothing.

Top module: `serial_shift_periph`

## Requirements
- R1: After reset, the shift register, the control word and the data word are all zero, and no write or read response is pending.
- R2: The control word sits at offset 0x00. Write-data bit 0 is the serial input and bit 1 is the shift enable; all higher bits are ignored. The write answers OKAY (2'b00). A read of 0x00 returns the two stored bits in bits 1:0, with every bit above them zero.
- R3: On each clock where the stored enable is 1, the shift register moves left by one and bit 0 takes the stored serial input. While the enable is 0, the shift register holds its value.
- R4: The data word sits at offset 0x04. On every clock it captures the shift register, so it lags the shift register by one cycle. A read of 0x04 returns it zero-extended, with response OKAY.
- R5: Four back-to-back enabled control writes carrying b3, b2, b1, b0, then one write with the enable clear, leave {b3,b2,b1,b0} readable at 0x04 from the second cycle after that last write.
- R6: A read of any address other than exactly 0x00 or 0x04 (misaligned addresses included) answers SLVERR (2'b10) with all-zero read data.
- R7: A write to any address other than 0x00, including the read-only 0x04, answers SLVERR (2'b10) and leaves both the control word and the data word unchanged.
- R8: A write is accepted only in a cycle where address and data are both valid. The write response is held until it is taken, and the next write can be accepted in the same cycle as that hand-off. A read response holds its data and code stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Write address valid |
| aw_addr_i | input | ADDR_W | Write byte address |
| aw_ready_o | output | 1 | Write address accepted |
| w_valid_i | input | 1 | Write data valid |
| w_data_i | input | DATA_W | Write data |
| w_ready_o | output | 1 | Write data accepted |
| b_valid_o | output | 1 | Write response valid |
| b_resp_o | output | 2 | Write response code |
| b_ready_i | input | 1 | Master takes write response |
| ar_valid_i | input | 1 | Read address valid |
| ar_addr_i | input | ADDR_W | Read byte address |
| ar_ready_o | output | 1 | Read address accepted |
| r_valid_o | output | 1 | Read response valid |
| r_data_o | output | DATA_W | Read data |
| r_resp_o | output | 2 | Read response code |
| r_ready_i | input | 1 | Master takes read response |

## Verification
Every control word written can be read back at 0x00 on the next read, so a corrupted enable or serial bit shows there at once. A bad enable also shows as a wrong shift result. A dropped or duplicated shift, or a mis-ordered bit, shows up in the value read at 0x04 no later than two cycles after the final disable write. A stale data-word capture shows as a read at 0x04 that is one bit behind. A decode fault shows up within one response as a wrong code, as non-zero error data, or as a register altered by a rejected write.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } resp_e;

  // en is bit 1, sin is bit 0 of the control word
  typedef struct packed {
    logic en;
    logic sin;
  } ctrl_t;
endpackage

// File: rtl/ssp_wr_port.sv
module ssp_wr_port
  import ssp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTRL_OFF = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aw_valid_i,
  input  logic [ADDR_W-1:0] aw_addr_i,
  output logic              aw_ready_o,
  input  logic              w_valid_i,
  input  logic [DATA_W-1:0] w_data_i,
  output logic              w_ready_o,
  output logic              b_valid_o,
  output logic [1:0]        b_resp_o,
  input  logic              b_ready_i,
  output ctrl_t             ctrl_o
);
  logic  b_valid_q;
  resp_e b_resp_q;
  ctrl_t ctrl_q;
  logic  wr_go, ctrl_hit;
  logic  unused_wdata;

  assign unused_wdata = ^w_data_i[DATA_W-1:2];

  // accept only with address and data together; slot frees as response leaves
  assign wr_go    = aw_valid_i & w_valid_i & (~b_valid_q | b_ready_i);
  assign ctrl_hit = (aw_addr_i == ADDR_W'(CTRL_OFF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_valid_q <= 1'b0;
      b_resp_q  <= RESP_OKAY;
      ctrl_q    <= '0;
    end else if (wr_go) begin
      b_valid_q <= 1'b1;
      b_resp_q  <= ctrl_hit ? RESP_OKAY : RESP_SLVERR;
      if (ctrl_hit) begin
        ctrl_q.sin <= w_data_i[0];
        ctrl_q.en  <= w_data_i[1];
      end
    end else if (b_ready_i) begin
      b_valid_q <= 1'b0;
    end
  end

  assign aw_ready_o = wr_go;
  assign w_ready_o  = wr_go;
  assign b_valid_o  = b_valid_q;
  assign b_resp_o   = b_resp_q;
  assign ctrl_o     = ctrl_q;

  p_b_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_valid_o && !b_ready_i) |=> (b_valid_o && $stable(b_resp_o)));

  p_ctrl_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_valid_i && w_valid_i && !ctrl_hit) |=> $stable(ctrl_o));

  p_err_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_ready_o && !ctrl_hit) |=> (b_valid_o && b_resp_o == RESP_SLVERR));
endmodule

// File: rtl/ssp_shift_core.sv
module ssp_shift_core #(
  parameter int unsigned SR_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            sin_i,
  output logic [SR_W-1:0] data_o
);
  logic [SR_W-1:0] sr_q, sr_d, data_q;

  for (genvar i = 0; i < SR_W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign sr_d[i] = en_i ? sin_i : sr_q[i];
    end else begin : g_upper
      assign sr_d[i] = en_i ? sr_q[i-1] : sr_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      data_q <= '0;
    end else begin
      sr_q   <= sr_d;
      data_q <= sr_q;
    end
  end

  assign data_o = data_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sr_q));

  p_lsb_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (sr_q[0] == $past(sin_i)));

  p_capture_lag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ##1 (data_o[0] == $past(sin_i, 2)));
endmodule

// File: rtl/ssp_rd_port.sv
module ssp_rd_port
  import ssp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SR_W     = 4,
  parameter int unsigned CTRL_OFF = 0,
  parameter int unsigned DATA_OFF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ar_valid_i,
  input  logic [ADDR_W-1:0] ar_addr_i,
  output logic              ar_ready_o,
  output logic              r_valid_o,
  output logic [DATA_W-1:0] r_data_o,
  output logic [1:0]        r_resp_o,
  input  logic              r_ready_i,
  input  ctrl_t             ctrl_i,
  input  logic [SR_W-1:0]   data_i
);
  logic              r_valid_q, rd_go;
  logic [DATA_W-1:0] r_data_q, rd_word;
  resp_e             r_resp_q, rd_resp;

  assign ar_ready_o = ~r_valid_q | r_ready_i;
  assign rd_go      = ar_valid_i & ar_ready_o;

  always_comb begin
    rd_word = '0;
    rd_resp = RESP_OKAY;
    if (ar_addr_i == ADDR_W'(CTRL_OFF)) begin
      rd_word[1:0] = {ctrl_i.en, ctrl_i.sin};
    end else if (ar_addr_i == ADDR_W'(DATA_OFF)) begin
      rd_word[SR_W-1:0] = data_i;
    end else begin
      rd_resp = RESP_SLVERR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_valid_q <= 1'b0;
      r_data_q  <= '0;
      r_resp_q  <= RESP_OKAY;
    end else if (rd_go) begin
      r_valid_q <= 1'b1;
      r_data_q  <= rd_word;
      r_resp_q  <= rd_resp;
    end else if (r_ready_i) begin
      r_valid_q <= 1'b0;
    end
  end

  assign r_valid_o = r_valid_q;
  assign r_data_o  = r_data_q;
  assign r_resp_o  = r_resp_q;

  p_r_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && !r_ready_i) |=> (r_valid_o && $stable(r_data_o) && $stable(r_resp_o)));

  p_err_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && r_resp_o == RESP_SLVERR) |-> (r_data_o == '0));

  p_ctrl_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && r_resp_o == RESP_OKAY) |-> (r_data_o[DATA_W-1:SR_W] == '0));
endmodule

// File: rtl/serial_shift_periph.sv
module serial_shift_periph
  import ssp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SR_W     = 4,
  parameter int unsigned CTRL_OFF = 0,
  parameter int unsigned DATA_OFF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aw_valid_i,
  input  logic [ADDR_W-1:0] aw_addr_i,
  output logic              aw_ready_o,
  input  logic              w_valid_i,
  input  logic [DATA_W-1:0] w_data_i,
  output logic              w_ready_o,
  output logic              b_valid_o,
  output logic [1:0]        b_resp_o,
  input  logic              b_ready_i,
  input  logic              ar_valid_i,
  input  logic [ADDR_W-1:0] ar_addr_i,
  output logic              ar_ready_o,
  output logic              r_valid_o,
  output logic [DATA_W-1:0] r_data_o,
  output logic [1:0]        r_resp_o,
  input  logic              r_ready_i
);
  ctrl_t           ctrl;
  logic [SR_W-1:0] data_word;

  ssp_wr_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFF(CTRL_OFF)
  ) u_wr (
    .clk_i, .rst_ni,
    .aw_valid_i, .aw_addr_i, .aw_ready_o,
    .w_valid_i, .w_data_i, .w_ready_o,
    .b_valid_o, .b_resp_o, .b_ready_i,
    .ctrl_o(ctrl)
  );

  ssp_shift_core #(.SR_W(SR_W)) u_core (
    .clk_i, .rst_ni,
    .en_i(ctrl.en), .sin_i(ctrl.sin),
    .data_o(data_word)
  );

  ssp_rd_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SR_W(SR_W),
    .CTRL_OFF(CTRL_OFF), .DATA_OFF(DATA_OFF)
  ) u_rd (
    .clk_i, .rst_ni,
    .ar_valid_i, .ar_addr_i, .ar_ready_o,
    .r_valid_o, .r_data_o, .r_resp_o, .r_ready_i,
    .ctrl_i(ctrl), .data_i(data_word)
  );

  p_aw_w_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_ready_o |-> (aw_valid_i && w_valid_i && w_ready_o));
endmodule

// File: tb/serial_shift_periph_test.sv
module serial_shift_periph_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [3:0]  pat;
    logic [31:0] exp;
  } vec_t;

  // R5 vectors: bits fed msb first, expected zero-extended word at 0x04
  localparam vec_t VECS [6] = '{
    '{4'b1011, 32'h0000_000B},
    '{4'b0000, 32'h0000_0000},
    '{4'b1111, 32'h0000_000F},
    '{4'b0110, 32'h0000_0006},
    '{4'b1000, 32'h0000_0008},
    '{4'b0001, 32'h0000_0001}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic aw_valid = 1'b0, w_valid = 1'b0, ar_valid = 1'b0;
  logic b_ready = 1'b1, r_ready = 1'b1;
  logic [ADDR_W-1:0] aw_addr = '0, ar_addr = '0;
  logic [DATA_W-1:0] w_data = '0;
  logic aw_ready, w_ready, b_valid, ar_ready, r_valid;
  logic [1:0] b_resp, r_resp;
  logic [DATA_W-1:0] r_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_shift_periph uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .aw_valid_i(aw_valid), .aw_addr_i(aw_addr), .aw_ready_o(aw_ready),
    .w_valid_i(w_valid), .w_data_i(w_data), .w_ready_o(w_ready),
    .b_valid_o(b_valid), .b_resp_o(b_resp), .b_ready_i(b_ready),
    .ar_valid_i(ar_valid), .ar_addr_i(ar_addr), .ar_ready_o(ar_ready),
    .r_valid_o(r_valid), .r_data_o(r_data), .r_resp_o(r_resp), .r_ready_i(r_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic [1:0] resp);
    ar_valid = 1'b0;
    aw_valid = 1'b1; aw_addr = a;
    w_valid  = 1'b1; w_data  = d;
    @(negedge clk);
    resp = b_valid ? b_resp : 2'bxx;
  endtask

  task automatic idle(input int n);
    aw_valid = 1'b0; w_valid = 1'b0; ar_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [1:0] resp);
    aw_valid = 1'b0; w_valid = 1'b0;
    ar_valid = 1'b1; ar_addr = a;
    @(negedge clk);
    d = r_data; resp = r_valid ? r_resp : 2'bxx;
    ar_valid = 1'b0;
  endtask

  task automatic load(input logic [3:0] pat);
    logic [1:0] resp;
    for (int k = 3; k >= 0; k--) begin
      wr(8'h00, {30'b0, 1'b1, pat[k]}, resp);
      check("R2 ctrl write okay", {30'b0, resp}, 32'h0);
    end
    wr(8'h00, {31'b0, pat[0]}, resp);
    check("R2 ctrl disable write okay", {30'b0, resp}, 32'h0);
    idle(1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  resp;
    repeat (3) @(negedge clk);
    check("R1 b_valid in reset", {31'b0, b_valid}, 32'h0);
    check("R1 r_valid in reset", {31'b0, r_valid}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(8'h04, d, resp);
    check("R1 data word after reset", d, 32'h0);
    rd(8'h00, d, resp);
    check("R1 ctrl word after reset", d, 32'h0);

    // table walk (R5, R4)
    for (int i = 0; i < 6; i++) begin
      load(VECS[i].pat);
      rd(8'h04, d, resp);
      check("R5 serial load result", d, VECS[i].exp);
      check("R4 data read okay", {30'b0, resp}, 32'h0);
    end

    // R4 lag: one cycle after final shift the data word is one step behind
    load(4'b0000);
    wr(8'h00, 32'h3, resp);          // en=1 sin=1
    wr(8'h00, 32'h0, resp);          // shift at this edge uses en=1
    rd(8'h04, d, resp);              // data word captured before last shift
    check("R4 capture lag", d, 32'h0);
    rd(8'h04, d, resp);
    check("R3 single shift left", d, 32'h1);
    wr(8'h00, 32'h2, resp);          // en=1 sin=0
    wr(8'h00, 32'h0, resp);
    idle(1);
    rd(8'h04, d, resp);
    check("R3 shift moves bit up", d, 32'h2);
    idle(5);
    rd(8'h04, d, resp);
    check("R3 hold while disabled", d, 32'h2);

    // R2 upper bits ignored, readback
    wr(8'h00, 32'hFFFF_FFF1, resp);
    check("R2 write okay", {30'b0, resp}, 32'h0);
    rd(8'h00, d, resp);
    check("R2 ctrl readback upper zero", d, 32'h1);

    // R7 rejected writes
    load(4'b1011);
    wr(8'h04, 32'hFFFF_FFFF, resp);
    check("R7 write to data word err", {30'b0, resp}, 32'h2);
    wr(8'h08, 32'h0000_0003, resp);
    check("R7 write to unmapped err", {30'b0, resp}, 32'h2);
    wr(8'h01, 32'h0000_0002, resp);
    check("R7 misaligned write err", {30'b0, resp}, 32'h2);
    idle(3);
    rd(8'h00, d, resp);
    check("R7 ctrl untouched", d, 32'h1);
    rd(8'h04, d, resp);
    check("R7 data untouched", d, 32'hB);

    // R6 unmapped reads
    rd(8'h10, d, resp);
    check("R6 unmapped read err", {30'b0, resp}, 32'h2);
    check("R6 unmapped read zero", d, 32'h0);
    rd(8'h02, d, resp);
    check("R6 misaligned read err", {30'b0, resp}, 32'h2);

    // R8 address without data is not accepted
    aw_valid = 1'b1; aw_addr = 8'h00; w_valid = 1'b0; w_data = 32'h3;
    @(negedge clk);
    check("R8 no accept without data", {31'b0, aw_ready}, 32'h0);
    @(negedge clk);
    check("R8 no response without data", {31'b0, b_valid}, 32'h0);
    idle(1);
    rd(8'h00, d, resp);
    check("R8 ctrl unchanged by lone address", d, 32'h1);

    // R8 write response hold
    b_ready = 1'b0;
    wr(8'h08, 32'h0, resp);
    idle(3);
    check("R8 b_valid held", {31'b0, b_valid}, 32'h1);
    check("R8 b_resp held", {30'b0, b_resp}, 32'h2);
    b_ready = 1'b1;
    @(negedge clk);
    check("R8 b_valid drops after take", {31'b0, b_valid}, 32'h0);

    // R8 read response hold
    r_ready = 1'b0;
    rd(8'h04, d, resp);
    idle(3);
    check("R8 r_valid held", {31'b0, r_valid}, 32'h1);
    check("R8 r_data held", r_data, 32'hB);
    r_ready = 1'b1;
    @(negedge clk);
    check("R8 r_valid drops after take", {31'b0, r_valid}, 32'h0);

    // R1 reset mid-run
    load(4'b1111);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(8'h04, d, resp);
    check("R1 data cleared by reset", d, 32'h0);
    rd(8'h00, d, resp);
    check("R1 ctrl cleared by reset", d, 32'h0);
    idle(2);
    rd(8'h04, d, resp);
    check("R1 no shift after reset", d, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule